// File: doc/BRIEF.md
# Reference Soft-Start Sequencer

This block sequences the start-up of a regulator whose voltage reference is set digitally. It runs on the switching-cycle clock, so one clock is one switching period. When both enable inputs are high and the six-bit VID code is a valid (non-no-load) code, it starts a soft-start. The soft-start first holds the reference code at zero for a fixed delay. It then ramps the code towards the decoded target at a constant slope. Early in the ramp it takes steps of two codes; later it takes steps of one code. Each reference code is 12.5 mV.

In parallel, the block drives a remote-sense offset code. This code starts at 100 mV and decays to zero over the first 640 ramp cycles. The PWM stage stays in high impedance until an external comparator reports that the rising reference has met the sensed output voltage. This protects a pre-biased output.

Two VID codes mean that no load is present. Receiving either one sends the block through a two-cycle wait into shutdown, where it selects the shutdown overvoltage threshold. An overvoltage detection latches a fault that only reset clears.

Top module: `ssSequencer`

## Requirements
- R1: After reset, refCode, senseOffset, pwmDrive, ovLevelShutdown, ovLatched and softStartDone are all zero.
- R2: A soft-start begins only on an edge where enCmpOk and enLogic are both high and vidCode is neither 6'b111111 nor 6'b111110. With either enable low, the block stays idle, with refCode and senseOffset at zero.
- R3: Call the edge that starts a soft-start edge 0. From edge 1 through edge 64, refCode stays at zero. From edge 1 on, senseOffset reads 8, which is 100 mV in 12.5 mV units.
- R4: In ramp cycles 0 to 639, refCode rises by 2 every 32 cycles. It reads 2 after edge 96 and 40 after edge 704.
- R5: After ramp cycle 640, refCode rises by 1 every 16 cycles. It reads 41 after edge 720. For a target of N codes with N even or N ≥ 40, refCode reaches N after edge 64+16·N.
- R6: refCode never passes targetCode. A two-code step that would overshoot is clamped to the target, so an odd target N below 40 is reached after edge 64+16·(N+1). softStartDone is high exactly while ramping with refCode equal to targetCode.
- R7: senseOffset falls by one every 80 ramp cycles. It reads 7 after edge 144 and reaches 0 after edge 704.
- R8: pwmDrive stays 0 (high impedance) outside the ramp. It goes to 1 one edge after refAtOutput is seen high during the ramp, and stays at 1 after refAtOutput falls.
- R9: If a no-load VID code is sampled on edge A, the outputs keep their values after edges A and A+1. After edge A+2, ovLevelShutdown is 1 and pwmDrive is 0. After edge A+3, refCode is 0. A valid code with both enables high then starts a new soft-start.
- R10: ovDetect sets ovLatched on the next edge and forces pwmDrive to 0 and ovLevelShutdown to 1; refCode is 0 one edge later. Neither VID codes nor toggling the enables restart the block or clear the flag. Only reset clears it.
- R11: Dropping either enable sets pwmDrive to 0 on the next edge, and refCode and senseOffset to 0 on the edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enCmpOk | input | 1 | Result of the threshold enable comparator |
| enLogic | input | 1 | Logic-level enable |
| vidCode | input | 6 | Raw VID code, checked for the no-load codes |
| targetCode | input | TW (8) | Decoded target level in 12.5 mV codes |
| refAtOutput | input | 1 | Reference has reached the sensed output voltage |
| ovDetect | input | 1 | Overvoltage comparator result |
| refCode | output | TW (8) | Reference code to the DAC, 12.5 mV per code |
| senseOffset | output | 4 | Remote-sense offset, 12.5 mV per code |
| pwmDrive | output | 1 | 1 drives PWM, 0 holds it in high impedance |
| ovLevelShutdown | output | 1 | Selects the shutdown overvoltage threshold |
| ovLatched | output | 1 | Sticky overvoltage fault flag |
| softStartDone | output | 1 | Ramp has reached the target |

## Verification
The ramp-path assertions assume that targetCode does not drop below the current reference while a soft-start is running. The stimulus therefore changes targetCode only while the block is idle or shut down, after refCode has returned to zero. The control assertions also assume that enables and VID code change only between clock edges. The bench drives every input at the falling edge, so each change is seen whole on the next rising edge.

// File: rtl/ssPkg.sv
package ssPkg;

  typedef enum logic [2:0] {
    SS_IDLE     = 3'd0,
    SS_DELAY    = 3'd1,
    SS_RAMP     = 3'd2,
    SS_SHUTWAIT = 3'd3,
    SS_SHUT     = 3'd4,
    SS_FAULT    = 3'd5
  } ssState_t;

  // control -> ramp path strobes, decoded from the current state
  typedef struct packed {
    logic clearAll;  // reference, offset and counters to zero
    logic arm;       // reference zero, offset loaded, counters zero
    logic run;       // advance the ramp by one switching cycle
  } ssStrobe_t;

  function automatic logic isNoLoadCode(input logic [5:0] code);
    return (code == 6'b111111) || (code == 6'b111110);
  endfunction

endpackage

// File: rtl/ssControl.sv
module ssControl
  import ssPkg::*;
#(
  parameter int DELAY_CYCLES    = 64,
  parameter int SHUTWAIT_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enCmpOk,
  input  logic      enLogic,
  input  logic [5:0] vidCode,
  input  logic      refAtOutput,
  input  logic      ovDetect,
  input  logic      atTarget,
  output ssStrobe_t strobe,
  output logic      pwmDrive,
  output logic      ovLevelShutdown,
  output logic      ovLatched,
  output logic      softStartDone
);

  localparam int DW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam int SW = (SHUTWAIT_CYCLES > 1) ? $clog2(SHUTWAIT_CYCLES) : 1;
  localparam logic [DW-1:0] DELAY_LAST = DW'(DELAY_CYCLES - 1);
  localparam logic [SW-1:0] SHUT_LAST  = SW'(SHUTWAIT_CYCLES - 1);

  ssState_t stateQ, stateNext;
  logic [DW-1:0] delayCnt;
  logic [SW-1:0] waitCnt;
  logic pwmQ, pwmNext;
  logic ovLatchedQ;
  logic bothEn, noLoad;

  assign bothEn = enCmpOk & enLogic;
  assign noLoad = isNoLoadCode(vidCode);

  always_comb begin
    stateNext = stateQ;
    if (ovLatchedQ || ovDetect) begin
      stateNext = SS_FAULT;
    end else if (!bothEn) begin
      stateNext = SS_IDLE;
    end else if (noLoad && stateQ != SS_SHUTWAIT && stateQ != SS_SHUT) begin
      stateNext = SS_SHUTWAIT;
    end else begin
      unique case (stateQ)
        SS_IDLE:     stateNext = SS_DELAY;
        SS_DELAY:    if (delayCnt == DELAY_LAST) stateNext = SS_RAMP;
        SS_RAMP:     stateNext = SS_RAMP;
        SS_SHUTWAIT: if (waitCnt == SHUT_LAST) stateNext = SS_SHUT;
        SS_SHUT:     if (!noLoad) stateNext = SS_DELAY;
        SS_FAULT:    stateNext = SS_FAULT;
        default:     stateNext = SS_IDLE;
      endcase
    end
  end

  // PWM leaves high impedance only once the ramp meets the output
  always_comb begin
    unique case (stateNext)
      SS_RAMP:     pwmNext = pwmQ | ((stateQ == SS_RAMP) & refAtOutput);
      SS_SHUTWAIT: pwmNext = pwmQ;
      default:     pwmNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= SS_IDLE;
      delayCnt   <= '0;
      waitCnt    <= '0;
      pwmQ       <= 1'b0;
      ovLatchedQ <= 1'b0;
    end else begin
      stateQ   <= stateNext;
      delayCnt <= (stateQ == SS_DELAY && stateNext == SS_DELAY) ? delayCnt + 1'b1 : '0;
      waitCnt  <= (stateQ == SS_SHUTWAIT && stateNext == SS_SHUTWAIT) ? waitCnt + 1'b1 : '0;
      pwmQ     <= pwmNext;
      if (ovDetect) ovLatchedQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.clearAll = (stateQ == SS_IDLE) || (stateQ == SS_SHUT) || (stateQ == SS_FAULT);
    strobe.arm      = (stateQ == SS_DELAY);
    strobe.run      = (stateQ == SS_RAMP);
  end

  assign pwmDrive        = pwmQ;
  assign ovLevelShutdown = (stateQ == SS_SHUT) || (stateQ == SS_FAULT);
  assign ovLatched       = ovLatchedQ;
  assign softStartDone   = (stateQ == SS_RAMP) && atTarget;

  // R8: PWM is driven only while ramping or waiting out a no-load code
  p_pwm_only_in_ramp_r8: assert property (@(posedge clk) disable iff (!rstN)
    pwmQ |-> (stateQ == SS_RAMP || stateQ == SS_SHUTWAIT));

  // R10: the overvoltage flag never clears without reset
  p_ov_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovLatchedQ |=> ovLatchedQ);

  // R10: a latched fault keeps PWM off
  p_ov_blocks_pwm_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovLatchedQ |-> !pwmQ);

  // R11: losing an enable returns to idle on the next edge
  p_enable_drop_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!bothEn && !ovLatchedQ && !ovDetect) |=> (stateQ == SS_IDLE));

  // R9: the shutdown threshold is reached only through the wait state
  p_shut_after_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ovLevelShutdown) && !ovLatchedQ) |-> ($past(stateQ) == SS_SHUTWAIT));

endmodule

// File: rtl/ssRampPath.sv
module ssRampPath
  import ssPkg::*;
#(
  parameter int TW            = 8,
  parameter int OFFSET_INIT   = 8,
  parameter int PHASE1_CYCLES = 640,
  parameter int STEP1_PERIOD  = 32,
  parameter int STEP1_SIZE    = 2,
  parameter int STEP2_PERIOD  = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ssStrobe_t     strobe,
  input  logic [TW-1:0] targetCode,
  output logic [TW-1:0] refCode,
  output logic [$clog2(OFFSET_INIT+1)-1:0] senseOffset,
  output logic          atTarget
);

  localparam int S1B          = $clog2(STEP1_PERIOD);
  localparam int S2B          = $clog2(STEP2_PERIOD);
  localparam int RCW          = TW + S2B + 2;
  localparam int OW           = $clog2(OFFSET_INIT + 1);
  localparam int OFF_INTERVAL = PHASE1_CYCLES / OFFSET_INIT;
  localparam int OCW          = $clog2(OFF_INTERVAL);
  localparam logic [RCW-1:0] P1_END   = RCW'(PHASE1_CYCLES);
  localparam logic [OCW-1:0] OFF_LAST = OCW'(OFF_INTERVAL - 1);
  localparam logic [OW-1:0]  OFF_LOAD = OW'(OFFSET_INIT);

  logic [RCW-1:0] rampCnt;
  logic [OCW-1:0] offCnt;
  logic [TW-1:0]  refQ;
  logic [OW-1:0]  offQ;
  logic           phaseOne, stepTick;
  logic [TW:0]    stepSum;
  logic [TW-1:0]  refStepped;

  assign phaseOne = rampCnt < P1_END;
  assign stepTick = phaseOne ? (rampCnt[S1B-1:0] == '1) : (rampCnt[S2B-1:0] == '1);
  assign stepSum  = {1'b0, refQ} + (TW+1)'(phaseOne ? STEP1_SIZE : 1);
  assign refStepped = (stepSum > {1'b0, targetCode}) ? targetCode : stepSum[TW-1:0];
  assign atTarget = (refQ == targetCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampCnt <= '0;
      offCnt  <= '0;
      refQ    <= '0;
      offQ    <= '0;
    end else if (strobe.clearAll) begin
      rampCnt <= '0;
      offCnt  <= '0;
      refQ    <= '0;
      offQ    <= '0;
    end else if (strobe.arm) begin
      rampCnt <= '0;
      offCnt  <= '0;
      refQ    <= '0;
      offQ    <= OFF_LOAD;
    end else if (strobe.run) begin
      if (rampCnt != '1) rampCnt <= rampCnt + 1'b1;
      if (stepTick && !atTarget) refQ <= refStepped;
      if (offQ != '0) begin
        if (offCnt == OFF_LAST) begin
          offCnt <= '0;
          offQ   <= offQ - 1'b1;
        end else begin
          offCnt <= offCnt + 1'b1;
        end
      end
    end
  end

  assign refCode     = refQ;
  assign senseOffset = offQ;

  // R6: the reference never passes the target (target held during a run)
  p_ref_capped_r6: assert property (@(posedge clk) disable iff (!rstN)
    refQ <= targetCode);

  // R4: ramping never lowers the reference and moves it by at most one large step
  p_ramp_monotone_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |=> (refQ >= $past(refQ)) && ((refQ - $past(refQ)) <= TW'(STEP1_SIZE)));

  // R7: the sense offset only decays while ramping
  p_offset_decays_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |=> (offQ <= $past(offQ)));

endmodule

// File: rtl/ssSequencer.sv
module ssSequencer
  import ssPkg::*;
#(
  parameter int TW              = 8,
  parameter int DELAY_CYCLES    = 64,
  parameter int SHUTWAIT_CYCLES = 2,
  parameter int OFFSET_INIT     = 8,
  parameter int PHASE1_CYCLES   = 640,
  parameter int STEP1_PERIOD    = 32,
  parameter int STEP1_SIZE      = 2,
  parameter int STEP2_PERIOD    = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enCmpOk,
  input  logic          enLogic,
  input  logic [5:0]    vidCode,
  input  logic [TW-1:0] targetCode,
  input  logic          refAtOutput,
  input  logic          ovDetect,
  output logic [TW-1:0] refCode,
  output logic [$clog2(OFFSET_INIT+1)-1:0] senseOffset,
  output logic          pwmDrive,
  output logic          ovLevelShutdown,
  output logic          ovLatched,
  output logic          softStartDone
);

  ssStrobe_t strobe;
  logic      atTarget;

  ssControl #(
    .DELAY_CYCLES   (DELAY_CYCLES),
    .SHUTWAIT_CYCLES(SHUTWAIT_CYCLES)
  ) u_control (
    .clk            (clk),
    .rstN           (rstN),
    .enCmpOk        (enCmpOk),
    .enLogic        (enLogic),
    .vidCode        (vidCode),
    .refAtOutput    (refAtOutput),
    .ovDetect       (ovDetect),
    .atTarget       (atTarget),
    .strobe         (strobe),
    .pwmDrive       (pwmDrive),
    .ovLevelShutdown(ovLevelShutdown),
    .ovLatched      (ovLatched),
    .softStartDone  (softStartDone)
  );

  ssRampPath #(
    .TW           (TW),
    .OFFSET_INIT  (OFFSET_INIT),
    .PHASE1_CYCLES(PHASE1_CYCLES),
    .STEP1_PERIOD (STEP1_PERIOD),
    .STEP1_SIZE   (STEP1_SIZE),
    .STEP2_PERIOD (STEP2_PERIOD)
  ) u_rampPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .targetCode (targetCode),
    .refCode    (refCode),
    .senseOffset(senseOffset),
    .atTarget   (atTarget)
  );

endmodule

// File: tb/ssSequencer_bench.sv
module ssSequencer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enCmpOk = 1'b0;
  logic       enLogic = 1'b0;
  logic [5:0] vidCode = 6'h12;
  logic [7:0] targetCode = 8'd0;
  logic       refAtOutput = 1'b0;
  logic       ovDetect = 1'b0;
  logic [7:0] refCode;
  logic [3:0] senseOffset;
  logic       pwmDrive, ovLevelShutdown, ovLatched, softStartDone;

  int vectors = 0;
  int miscompares = 0;
  int cur = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ssSequencer u_ssSequencer (
    .clk(clk), .rstN(rstN), .enCmpOk(enCmpOk), .enLogic(enLogic),
    .vidCode(vidCode), .targetCode(targetCode), .refAtOutput(refAtOutput),
    .ovDetect(ovDetect), .refCode(refCode), .senseOffset(senseOffset),
    .pwmDrive(pwmDrive), .ovLevelShutdown(ovLevelShutdown),
    .ovLatched(ovLatched), .softStartDone(softStartDone)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", tag, what, act, exp, cur);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur++;
    end
  endtask

  task automatic advanceTo(input int k);
    while (cur < k) step(1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; enCmpOk = 1'b0; enLogic = 1'b0; vidCode = 6'h12;
    refAtOutput = 1'b0; ovDetect = 1'b0; targetCode = 8'd0;
    step(3);
    rstN = 1'b1;
    step(1);
  endtask

  // drive a start at this falling edge; the next rising edge is edge 0
  task automatic startRun(input int tgt);
    targetCode = 8'(tgt); vidCode = 6'h12; enCmpOk = 1'b1; enLogic = 1'b1;
    cur = -1;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic testReset();
    doReset();
    chk("R1", "refCode", refCode, 0);
    chk("R1", "senseOffset", senseOffset, 0);
    chk("R1", "pwmDrive", pwmDrive, 0);
    chk("R1", "ovLevelShutdown", ovLevelShutdown, 0);
    chk("R1", "ovLatched", ovLatched, 0);
    chk("R1", "softStartDone", softStartDone, 0);
  endtask

  task automatic testGating();
    doReset();
    targetCode = 8'd20; enCmpOk = 1'b1; enLogic = 1'b0;
    step(10);
    chk("R2", "offset logic-enable low", senseOffset, 0);
    chk("R2", "ref logic-enable low", refCode, 0);
    enCmpOk = 1'b0; enLogic = 1'b1;
    step(10);
    chk("R2", "offset comparator low", senseOffset, 0);
    enCmpOk = 1'b1; vidCode = 6'b111110;
    step(10);
    chk("R2", "offset no-load code", senseOffset, 0);
    chk("R9", "shutdown level from idle", ovLevelShutdown, 1);
    vidCode = 6'b111111;
    step(5);
    chk("R2", "offset second no-load code", senseOffset, 0);
    vidCode = 6'h12;
    step(2);
    chk("R2", "offset after valid code", senseOffset, 8);
  endtask

  task automatic testFullRamp();
    doReset();
    startRun(44);
    advanceTo(1);
    chk("R3", "offset at start", senseOffset, 8);
    chk("R3", "ref at start", refCode, 0);
    advanceTo(64);
    chk("R3", "ref end of delay", refCode, 0);
    advanceTo(95);
    chk("R4", "ref before first step", refCode, 0);
    advanceTo(96);
    chk("R4", "ref first step", refCode, 2);
    advanceTo(143);
    chk("R7", "offset before decay", senseOffset, 8);
    advanceTo(144);
    chk("R7", "offset first decay", senseOffset, 7);
    advanceTo(300);
    chk("R8", "pwm hiZ without match", pwmDrive, 0);
    advanceTo(703);
    chk("R7", "offset before zero", senseOffset, 1);
    advanceTo(704);
    chk("R4", "ref end of phase one", refCode, 40);
    chk("R7", "offset zero", senseOffset, 0);
    advanceTo(719);
    chk("R5", "ref before fine step", refCode, 40);
    advanceTo(720);
    chk("R5", "ref first fine step", refCode, 41);
    advanceTo(767);
    chk("R6", "done early", softStartDone, 0);
    advanceTo(768);
    chk("R5", "ref at target", refCode, 44);
    chk("R6", "done at target", softStartDone, 1);
    advanceTo(800);
    chk("R6", "ref held", refCode, 44);
    refAtOutput = 1'b1;
    step(1);
    chk("R8", "pwm drives after match", pwmDrive, 1);
    refAtOutput = 1'b0;
    step(3);
    chk("R8", "pwm stays driven", pwmDrive, 1);
    // R9: no-load code
    vidCode = 6'b111111;
    step(1);
    chk("R9", "pwm after A", pwmDrive, 1);
    chk("R9", "level after A", ovLevelShutdown, 0);
    step(1);
    chk("R9", "pwm after A+1", pwmDrive, 1);
    chk("R9", "level after A+1", ovLevelShutdown, 0);
    step(1);
    chk("R9", "pwm after A+2", pwmDrive, 0);
    chk("R9", "level after A+2", ovLevelShutdown, 1);
    step(1);
    chk("R9", "ref after A+3", refCode, 0);
    // restart with an odd target below the coarse region
    startRun(3);
    advanceTo(1);
    chk("R9", "restart offset", senseOffset, 8);
    chk("R9", "level cleared on restart", ovLevelShutdown, 0);
    advanceTo(96);
    chk("R6", "odd target first step", refCode, 2);
    advanceTo(127);
    chk("R6", "odd target before clamp", refCode, 2);
    chk("R6", "not done", softStartDone, 0);
    advanceTo(128);
    chk("R6", "odd target clamped", refCode, 3);
    chk("R6", "done odd target", softStartDone, 1);
  endtask

  task automatic testEnableDrop();
    doReset();
    startRun(44);
    refAtOutput = 1'b1;
    advanceTo(64);
    chk("R8", "pwm hiZ at end of delay", pwmDrive, 0);
    advanceTo(65);
    chk("R8", "pwm on first ramp match", pwmDrive, 1);
    advanceTo(200);
    chk("R4", "ref mid phase one", refCode, 8);
    enLogic = 1'b0;
    step(1);
    chk("R11", "pwm off next edge", pwmDrive, 0);
    step(1);
    chk("R11", "ref zero", refCode, 0);
    chk("R11", "offset zero", senseOffset, 0);
    chk("R11", "done low", softStartDone, 0);
  endtask

  task automatic testOverVoltage();
    doReset();
    startRun(44);
    refAtOutput = 1'b1;
    advanceTo(100);
    ovDetect = 1'b1;
    step(1);
    ovDetect = 1'b0;
    chk("R10", "flag set", ovLatched, 1);
    chk("R10", "pwm off", pwmDrive, 0);
    chk("R10", "shutdown level", ovLevelShutdown, 1);
    step(1);
    chk("R10", "ref zero", refCode, 0);
    vidCode = 6'b111111;
    step(4);
    vidCode = 6'h12;
    step(100);
    chk("R10", "no restart by vid offset", senseOffset, 0);
    chk("R10", "no restart by vid ref", refCode, 0);
    chk("R10", "flag kept by vid", ovLatched, 1);
    enCmpOk = 1'b0;
    step(3);
    enCmpOk = 1'b1;
    step(100);
    chk("R10", "no restart by enable ref", refCode, 0);
    chk("R10", "no restart by enable pwm", pwmDrive, 0);
    chk("R10", "flag kept by enable", ovLatched, 1);
    doReset();
    chk("R10", "reset clears flag", ovLatched, 0);
    chk("R10", "reset clears level", ovLevelShutdown, 0);
  endtask

  initial begin
    testReset();
    testGating();
    testFullRamp();
    testEnableDrop();
    testOverVoltage();
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

endmodule